// File: doc/BRIEF.md
# Serial Register Access Port

This block is a serial slave port that lets an external host read and write a byte-wide register space inside the chip. The host lowers chip select to open a frame. It then shifts in a 16-bit control word followed by any number of data bytes. The control word holds a direction flag in its top bit and a 15-bit starting address below it. Every byte after the first targets the next address, which the block computes itself; the address wraps from the top of the space back to zero.

The serial clock, chip select and incoming data line are brought into the system clock domain through two-flop synchronizers, and edges are found from the synchronized samples. The serial clock must therefore be much slower than the system clock. A static mode input selects either a separate output line (4-wire) or a single data line that turns around for read data (3-wire). On the register side, the block presents an address and a one-cycle write strobe with write data. It receives read data and a flag that tells it whether the current address holds a register.

Top module: `spi_regport`

## Requirements
- R1: While chip select is high, serial clock and data activity causes no register write and no output drive. Raising chip select at any point leaves the port ready to decode a fresh control word in the next frame.
- R2: Data is sampled on the rising serial clock edge, most significant bit first. The first 16 bits form the control word: bit 15 = 1 requests a read, bit 15 = 0 a write, and bits 14..0 give the starting byte address.
- R3: In a write frame, each complete 8-bit data byte produces exactly one write strobe, one system clock wide. During that strobe, the address and write data show the byte and the address it belongs to.
- R4: Each byte after the first in a frame uses the previous address plus one, modulo 2^15, so address 0x7FFF is followed by 0x0000.
- R5: In a read frame, the byte at the current address is returned most significant bit first. Each bit changes after a falling serial clock edge, and the first bit follows the falling edge after the sixteenth rising edge.
- R6: With the mode input low (4-wire), read data appears on sdo and the block never drives sdio. With the mode input high (3-wire), read data appears on sdio and sdo stays undriven.
- R7: Both data outputs are high-impedance whenever chip select is high, and also during control words and write frames.
- R8: A frame that ends before the control word is complete, or during the first data byte, performs no register write.
- R9: A frame that ends later keeps every byte that was fully transferred. The partial byte produces no write.
- R10: When the address-valid flag is low, a write byte produces no strobe and a read byte returns 0x00. Address stepping continues as for a valid address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host, low when idle |
| sdio | inout | 1 | Serial data in; also read data out in 3-wire mode |
| sdo | output | 1 | Read data out in 4-wire mode, otherwise high-impedance |
| three_wire | input | 1 | Static mode select: 1 = 3-wire, 0 = 4-wire |
| reg_addr | output | 15 | Register address of the current byte |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data, valid with reg_wr |
| reg_rdata | input | 8 | Read data for reg_addr |
| reg_addr_valid | input | 1 | High when reg_addr holds a register |

## Verification
The sensitive overlap is between a chip select rise that ends a frame and the completion of a byte. The write strobe and address step for the last full byte can land in the same few system clocks as the synchronized frame end. Separately, the release of the output drive competes with the falling-edge shift of the next read bit. The bench provokes this by cutting frames a few bits after a byte boundary and, in multi-byte reads and writes, cutting them half a serial clock after the final falling edge. Every clock it compares the strobes against a queue of predicted writes and checks that both data lines read as released whenever chip select is high.

// File: rtl/spi_regport_pkg.sv
// Package: shared types for the serial register access port.
// Assumes nothing beyond the default parameter values used by the top.
package spi_regport_pkg;

    // Frame phase: shifting the control word, or moving data bytes.
    typedef enum logic {
        PH_CTRL = 1'b0,
        PH_DATA = 1'b1
    } frame_phase_e;

    // Bit positions of the synchronized input bundle.
    localparam int SIG_CS   = 2;
    localparam int SIG_SCLK = 1;
    localparam int SIG_SDI  = 0;
    localparam int SIG_N    = 3;

endpackage

// File: rtl/spi_regport_sync.sv
// Module: spi_regport_sync
// Brings chip select, serial clock and serial data into the system clock
// domain through a chain of STAGES flops. All three travel the same chain,
// so data stays aligned with the clock edge that samples it. Rising and
// falling serial clock edges are reported only while the synchronized chip
// select is active.
// Assumes: each serial clock phase lasts at least STAGES+2 system clocks.
module spi_regport_sync
    import spi_regport_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic cs_act,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic din
);

    localparam logic [SIG_N-1:0] IDLE_VAL = 3'b100;   // deselected, clock low, data low

    logic [SIG_N-1:0] chain [STAGES];
    logic             sclk_prev;
    logic [SIG_N-1:0] raw;
    logic [SIG_N-1:0] synced;

    assign raw    = {cs_n, sclk, sdi};
    assign synced = chain[STAGES-1];

    // Shift the raw pins through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= IDLE_VAL;
        end else begin
            chain[0] <= raw;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    // Hold the previous synchronized clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= synced[SIG_SCLK];
    end

    assign cs_act    = ~synced[SIG_CS];
    assign sclk_rise = cs_act &  synced[SIG_SCLK] & ~sclk_prev;
    assign sclk_fall = cs_act & ~synced[SIG_SCLK] &  sclk_prev;
    assign din       = synced[SIG_SDI];

endmodule

// File: rtl/spi_regport_frame.sv
// Module: spi_regport_frame
// Decodes the frame: collects the control word and shifts write bytes in
// (strobing one write per complete byte). It loads read bytes from the
// register side and shifts them out on falling edges, and it steps the
// address by one per byte with wrap-around. Dropping chip select returns
// the decoder to the control phase; bytes already strobed are kept, and a
// partial byte is never strobed.
// Assumes: edge pulses from spi_regport_sync, at least three system clocks
// apart, and reg_rdata/reg_addr_valid combinational in reg_addr.
module spi_regport_frame
    import spi_regport_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              din,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic              reg_addr_valid,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              rd_drive,
    output logic              out_bit
);

    localparam int CTRL_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(CTRL_W);
    localparam logic [CNT_W-1:0] CTRL_LAST = CNT_W'(CTRL_W - 1);
    localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(DATA_W - 1);

    frame_phase_e      phase;
    logic [CNT_W-1:0]  bit_cnt;
    logic [ADDR_W-1:0] ctrl_sr;     // direction flag plus upper address bits
    logic [DATA_W-1:0] wr_sr;
    logic [DATA_W-1:0] rd_sr;
    logic              rd_mode;
    logic              armed;
    logic              step_pend;   // advance address the cycle after a write strobe
    logic              load_pend;   // fetch read byte the cycle after the address settles
    logic              ctrl_done;
    logic              byte_done;

    assign ctrl_done = sclk_rise && (phase == PH_CTRL) && (bit_cnt == CTRL_LAST);
    assign byte_done = sclk_rise && (phase == PH_DATA) && (bit_cnt == BYTE_LAST);

    // Frame sequencing, shifting, strobing and address stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_CTRL;
            bit_cnt   <= '0;
            ctrl_sr   <= '0;
            wr_sr     <= '0;
            rd_sr     <= '0;
            rd_mode   <= 1'b0;
            armed     <= 1'b0;
            step_pend <= 1'b0;
            load_pend <= 1'b0;
            reg_addr  <= '0;
            reg_wr    <= 1'b0;
            reg_wdata <= '0;
            out_bit   <= 1'b0;
        end else begin
            reg_wr    <= 1'b0;
            step_pend <= 1'b0;
            load_pend <= 1'b0;
            // R4: write frames step after the strobe so the address is stable during it.
            if (step_pend) reg_addr <= reg_addr + 1'b1;
            // R10: an undefined register reads as zero.
            if (load_pend) rd_sr <= reg_addr_valid ? reg_rdata : '0;

            if (!cs_act) begin
                // R1/R8: deselect returns to the control phase and drops partial work.
                phase   <= PH_CTRL;
                bit_cnt <= '0;
                rd_mode <= 1'b0;
                armed   <= 1'b0;
            end else if (sclk_rise) begin
                if (phase == PH_CTRL) begin
                    ctrl_sr <= {ctrl_sr[ADDR_W-2:0], din};
                    if (ctrl_done) begin
                        // R2: top bit selects direction, the rest is the start address.
                        rd_mode   <= ctrl_sr[ADDR_W-1];
                        reg_addr  <= {ctrl_sr[ADDR_W-2:0], din};
                        phase     <= PH_DATA;
                        bit_cnt   <= '0;
                        load_pend <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end else begin
                    wr_sr <= {wr_sr[DATA_W-2:0], din};
                    if (byte_done) begin
                        bit_cnt <= '0;
                        if (rd_mode) begin
                            reg_addr  <= reg_addr + 1'b1;
                            load_pend <= 1'b1;
                        end else begin
                            // R3/R10: one strobe per full byte, suppressed for undefined addresses.
                            reg_wdata <= {wr_sr[DATA_W-2:0], din};
                            reg_wr    <= reg_addr_valid;
                            step_pend <= 1'b1;
                        end
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            end else if (sclk_fall && (phase == PH_DATA) && rd_mode) begin
                // R5: present the next bit after each falling edge.
                armed   <= 1'b1;
                out_bit <= rd_sr[DATA_W-1];
                rd_sr   <= {rd_sr[DATA_W-2:0], 1'b0};
            end
        end
    end

    assign rd_drive = armed;

endmodule

// File: rtl/spi_regport_pad.sv
// Module: spi_regport_pad
// Steers read data to the output line chosen by the mode input, and gates
// the output enables with the raw chip select. The lines therefore float
// as soon as the host deselects, without waiting for the synchronizer.
// Assumes: three_wire changes only while chip select is high.
module spi_regport_pad (
    input  logic cs_n,
    input  logic three_wire,
    input  logic rd_drive,
    input  logic out_bit,
    output logic sdo_oe,
    output logic sdio_oe,
    output logic line_bit
);

    // Pick one output line for read data and float it when deselected.
    always_comb begin
        sdo_oe   = ~cs_n & rd_drive & ~three_wire;
        sdio_oe  = ~cs_n & rd_drive &  three_wire;
        line_bit = out_bit;
    end

endmodule

// File: rtl/spi_regport.sv
// Module: spi_regport (top)
// Serial slave port giving a host byte access to a register space:
// synchronizer, frame decoder and pad steering. The tri-state drivers live
// here so both data lines are resolved at the block boundary.
// Assumes: sclk idles low, is slower than clk by a factor of at least ten,
// and three_wire is static during a frame.
module spi_regport #(
    parameter int ADDR_W      = 15,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    inout  wire               sdio,
    output wire               sdo,
    input  logic              three_wire,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic              reg_addr_valid
);

    logic cs_act;
    logic sclk_rise;
    logic sclk_fall;
    logic din;
    logic rd_drive;
    logic out_bit;
    logic sdo_oe;
    logic sdio_oe;
    logic line_bit;

    spi_regport_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdi       (sdio),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .din       (din)
    );

    spi_regport_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .clk            (clk),
        .rst_n          (rst_n),
        .cs_act         (cs_act),
        .sclk_rise      (sclk_rise),
        .sclk_fall      (sclk_fall),
        .din            (din),
        .reg_rdata      (reg_rdata),
        .reg_addr_valid (reg_addr_valid),
        .reg_addr       (reg_addr),
        .reg_wr         (reg_wr),
        .reg_wdata      (reg_wdata),
        .rd_drive       (rd_drive),
        .out_bit        (out_bit)
    );

    spi_regport_pad u_pad (
        .cs_n       (cs_n),
        .three_wire (three_wire),
        .rd_drive   (rd_drive),
        .out_bit    (out_bit),
        .sdo_oe     (sdo_oe),
        .sdio_oe    (sdio_oe),
        .line_bit   (line_bit)
    );

    // R6/R7: tri-state drivers for the two data lines.
    assign sdo  = sdo_oe  ? line_bit : 1'bz;
    assign sdio = sdio_oe ? line_bit : 1'bz;

endmodule

// File: rtl/spi_regport_chk.sv
// Module: spi_regport_chk
// Temporal checks on the port, bound into every spi_regport instance.
// Assumes: reset asserted at time zero.
module spi_regport_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_act,
    input logic              rd_drive,
    input logic              sdo_oe,
    input logic              sdio_oe,
    input logic              three_wire,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_addr_valid
);

    a_r1_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_act && $past(!cs_act)) |-> !reg_wr);

    a_r7_no_drive_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_act && $past(!cs_act)) |-> !rd_drive);

    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    a_r4_step_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_addr == ADDR_W'($past(reg_addr) + 1'b1)));

    a_r10_strobe_valid: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> reg_addr_valid);

    a_r6_sdo_quiet_3wire: assert property (@(posedge clk) disable iff (!rst_n)
        three_wire |-> !sdo_oe);

    a_r6_sdio_quiet_4wire: assert property (@(posedge clk) disable iff (!rst_n)
        !three_wire |-> !sdio_oe);

endmodule

bind spi_regport spi_regport_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cs_act         (cs_act),
    .rd_drive       (rd_drive),
    .sdo_oe         (sdo_oe),
    .sdio_oe        (sdio_oe),
    .three_wire     (three_wire),
    .reg_wr         (reg_wr),
    .reg_addr       (reg_addr),
    .reg_addr_valid (reg_addr_valid)
);

// File: tb/spi_regport_tb.sv
// Bench: host-side frame driver, behavioural register space and a queue
// model of the writes each frame should produce, compared on every clock.
module spi_regport_tb;

    localparam int HALF  = 6;        // system clocks per serial clock phase
    localparam int AMASK = 32'h7FFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        three_wire = 1'b0;
    logic        host_oe = 1'b1;
    logic        host_bit = 1'b0;
    logic [14:0] reg_addr;
    logic        reg_wr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata = 8'h00;
    logic        reg_addr_valid;
    wire         sdio_w;
    wire         sdo_w;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;
    bit prev_wr = 1'b0;
    bit prev_cs = 1'b1;

    logic [7:0] regs   [int];        // register space seen by the block
    logic [7:0] shadow [int];        // model of what it should hold
    int exp_a[$];
    int exp_d[$];

    always #5 clk = ~clk;

    pullup (sdo_w);
    pullup (sdio_w);
    assign sdio_w = host_oe ? host_bit : 1'bz;

    function automatic bit addr_ok(input int a);
        return (a < 256) || (a >= 32'h7FF0);
    endfunction

    assign reg_addr_valid = addr_ok(int'(reg_addr));

    spi_regport u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cs_n           (cs_n),
        .sclk           (sclk),
        .sdio           (sdio_w),
        .sdo            (sdo_w),
        .three_wire     (three_wire),
        .reg_addr       (reg_addr),
        .reg_wr         (reg_wr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .reg_addr_valid (reg_addr_valid)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Register side plus per-clock comparison against the write queue.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (reg_wr) begin
                chk(!prev_wr, "R3", "strobe wider than one clock", 1, 0);
                if (exp_a.size() == 0) begin
                    chk(1'b0, "R3", "unexpected strobe at addr", int'(reg_addr), -1);
                end else begin
                    chk(int'(reg_addr) == exp_a[0], "R4", "strobe address",
                        int'(reg_addr), exp_a[0]);
                    chk(int'(reg_wdata) == exp_d[0], "R3", "strobe data",
                        int'(reg_wdata), exp_d[0]);
                    void'(exp_a.pop_front());
                    void'(exp_d.pop_front());
                end
                regs[int'(reg_addr)] = reg_wdata;
            end
            if (cs_n && prev_cs) begin
                chk(sdo_w == 1'b1, "R7", "sdo driven while deselected", int'(sdo_w), 1);
                if (!host_oe)
                    chk(sdio_w == 1'b1, "R7", "sdio driven while deselected", int'(sdio_w), 1);
            end
            prev_wr = reg_wr;
            prev_cs = cs_n;
        end
        reg_rdata = addr_ok(int'(reg_addr)) ? regs[int'(reg_addr)] : 8'hA5;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic int wbyte(input int addr, input int i);
        return (addr * 7 + i * 29 + 8'h11) & 8'hFF;
    endfunction

    // One host frame: rd selects direction, cut < 0 sends everything,
    // otherwise chip select rises after cut serial bits.
    task automatic xfer(input bit rd, input int addr, input int nbytes,
                        input int cut, input bit tw, input string req);
        int total;
        int full;
        logic [15:0] ctrl;
        logic [7:0] got;
        logic [7:0] exp_rd [$];
        total = (cut < 0) ? 16 + 8 * nbytes : cut;
        full  = (total < 16) ? 0 : (total - 16) / 8;
        if (full > nbytes) full = nbytes;
        ctrl = {rd, addr[14:0]};
        three_wire = tw;
        for (int i = 0; i < full; i++) begin
            int a;
            a = (addr + i) & AMASK;
            if (rd) begin
                exp_rd.push_back(addr_ok(a) ? shadow[a] : 8'h00);
            end else if (addr_ok(a)) begin
                exp_a.push_back(a);
                exp_d.push_back(wbyte(addr, i));
                shadow[a] = 8'(wbyte(addr, i));
            end
        end
        repeat (2) @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        got = 8'h00;
        for (int b = 0; b < total; b++) begin
            bit in_data;
            in_data = (b >= 16);
            if (!in_data)      host_bit = ctrl[15 - b];
            else if (!rd)      host_bit = 1'(wbyte(addr, (b - 16) / 8) >> (7 - (b - 16) % 8));
            else               host_bit = 1'b0;
            host_oe = !(rd && tw && in_data);
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            if (rd && in_data) begin
                got = {got[6:0], (tw ? sdio_w : sdo_w)};
                if (tw) chk(sdo_w == 1'b1, "R6", "sdo driven in 3-wire read", int'(sdo_w), 1);
                else    chk(sdio_w == 1'b0, "R6", "sdio disturbed in 4-wire read", int'(sdio_w), 0);
                if ((b - 16) % 8 == 7 && (b - 16) / 8 < full) begin
                    int k;
                    int a;
                    k = (b - 16) / 8;
                    a = (addr + k) & AMASK;
                    chk(got == exp_rd[k], addr_ok(a) ? req : "R10", "read byte",
                        int'(got), int'(exp_rd[k]));
                end
            end else if (!tw) begin
                chk(sdo_w == 1'b1, "R7", "sdo driven outside read data", int'(sdo_w), 1);
            end
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
        host_oe = 1'b1;
        repeat (8) @(negedge clk);
        chk(exp_a.size() == 0, req, "writes missing after frame", exp_a.size(), 0);
        exp_a.delete();
        exp_d.delete();
    endtask

    initial begin
        for (int a = 0; a < 256; a++) begin
            regs[a] = 8'(a ^ 8'h3C);
            shadow[a] = 8'(a ^ 8'h3C);
        end
        for (int a = 32'h7FF0; a <= 32'h7FFF; a++) begin
            regs[a] = 8'(a ^ 8'h5A);
            shadow[a] = 8'(a ^ 8'h5A);
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(reg_wr == 1'b0, "R3", "strobe after reset", int'(reg_wr), 0);
        chk(sdo_w == 1'b1, "R7", "sdo after reset", int'(sdo_w), 1);

        // R2/R3/R4: multi-byte write then read back, 4-wire.
        xfer(1'b0, 32'h0010, 3, -1, 1'b0, "R3");
        xfer(1'b1, 32'h0010, 3, -1, 1'b0, "R5");
        xfer(1'b1, 32'h0003, 1, -1, 1'b0, "R2");

        // R6: same in 3-wire mode.
        xfer(1'b0, 32'h0040, 2, -1, 1'b1, "R6");
        xfer(1'b1, 32'h0040, 2, -1, 1'b1, "R6");

        // R4: address wrap in both directions.
        xfer(1'b0, 32'h7FFE, 3, -1, 1'b0, "R4");
        xfer(1'b1, 32'h7FFE, 3, -1, 1'b1, "R4");

        // R10: undefined addresses discarded on write, zero on read, stepping continues.
        xfer(1'b0, 32'h1000, 2, -1, 1'b0, "R10");
        xfer(1'b1, 32'h00FF, 3, -1, 1'b0, "R10");
        xfer(1'b0, 32'h00FF, 3, -1, 1'b1, "R10");
        xfer(1'b1, 32'h00FE, 2, -1, 1'b0, "R10");

        // R8: cut inside the control word, then inside the first byte.
        xfer(1'b0, 32'h0020, 2, 10, 1'b0, "R8");
        xfer(1'b0, 32'h0020, 2, 21, 1'b0, "R8");
        xfer(1'b1, 32'h0020, 2, -1, 1'b0, "R8");

        // R9: cut mid-stream keeps complete bytes only.
        xfer(1'b0, 32'h0030, 4, 16 + 16 + 3, 1'b0, "R9");
        xfer(1'b1, 32'h0030, 4, -1, 1'b0, "R9");
        xfer(1'b1, 32'h0030, 4, 16 + 8 + 5, 1'b1, "R9");

        // R1: clock and data toggling while deselected does nothing.
        three_wire = 1'b0;
        for (int i = 0; i < 24; i++) begin
            host_bit = 1'(i % 3 == 0);
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        chk(reg_wr == 1'b0 && sdo_w == 1'b1, "R1", "activity while deselected",
            int'({reg_wr, sdo_w}), 1);
        xfer(1'b1, 32'h0011, 2, -1, 1'b0, "R1");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule